// File: doc/BRIEF.md
# Privileged Run-Flag Register Access Unit

This unit holds one architectural control flag, the run flag. It answers the special-register move requests that a core's execute stage sends to it. Each request names a 10-bit register number and says whether it is a read or a write. It also carries the requester's privilege level, the data to write, and the old contents of the destination, so that a request which must not change anything can hand that value back.

Reads and writes reach the flag through different register numbers. The read port, number 136, can be used from either privilege level. The write port, number 152, is reserved for privileged code. A read returns a different image at each privilege level. A read of the write port faults when it comes from user state and does nothing at all when it comes from privileged state. Requests for any other number pass through unhandled, so that a neighbouring unit can claim them. Responses are combinational and appear in the cycle the request is valid.

The flag is driven out on every cycle. It can enable performance counting and light a status indicator. Internally it is a two-state machine: `ST_HALTED` (flag 0) and `ST_RUNNING` (flag 1). Reset enters `ST_RUNNING`. A valid privileged write whose data bit 0 is 0 takes the `T_STOP` transition to `ST_HALTED`. One whose bit 0 is 1 takes the `T_START` transition to `ST_RUNNING`. Every other cycle takes `T_HOLD` and the state does not change. The request decoder sorts each request into one of six access kinds: `ACC_IDLE`, `ACC_FOREIGN`, `ACC_RD_FLAG`, `ACC_RD_WPORT`, `ACC_WR_FLAG` and `ACC_WR_RPORT`.

Top module: `ctlreg_access_unit`

## Requirements
- R1: After reset the run flag output is 1.
- R2: A valid privileged write to number 152 loads bit 0 of the write data into the run flag, visible on the next cycle. The response has handled=1, both faults 0 and read data 0.
- R3: A valid user-state write to number 152 gives handled=1 and privilege fault=1. The run flag does not change.
- R4: A valid write to number 136, at either privilege, gives handled=1 and no fault. The run flag does not change.
- R5: A valid user-state read of number 136 returns the run flag in bit 0, with every other bit 0. It gives handled=1 and no fault.
- R6: A valid privileged read of number 136 returns the run flag in both bit 0 and bit 15, with every other bit 0. It gives handled=1 and no fault.
- R7: A valid user-state read of number 152 gives illegal-instruction fault=1 and handled=1. The read data equals the old destination value.
- R8: A valid privileged read of number 152 returns the old destination value unchanged, with handled=1 and no fault.
- R9: A valid request to any number other than 136 and 152 gives handled=0, both faults 0 and read data 0.
- R10: When the request valid is low, every response output is 0 and the run flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_sprn | input | 10 | Special-register number |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_priv | input | 1 | 1 = privileged state, 0 = user state |
| req_wdata | input | 64 | Write data |
| req_old | input | 64 | Old destination value |
| resp_rdata | output | 64 | Read result |
| resp_handled | output | 1 | Request claimed by this unit |
| resp_illegal | output | 1 | Illegal-instruction fault |
| resp_priv_fault | output | 1 | Privilege fault |
| run_o | output | 1 | Current run flag |

## Verification
On every cycle, the assertions check these behaviours: the flag changes only after a privileged write to the write port, and such a write sets the flag to the written bit. The two read images must match the flag at each privilege level. A privileged read of the write port must pass the old value through. Foreign and idle requests must leave every response at 0, and the two fault flags must never be raised together. Some behaviours can only be shown by the bench's scripted sequences, because they depend on stimulus order. These are the reset value of the flag, a rejected write followed by a read that proves nothing changed, and the user-state read fault.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
    localparam int SPRN_W     = 10;
    localparam int DATA_W     = 64;
    localparam int RD_NUM     = 136;
    localparam int WR_NUM     = 152;
    localparam int MIRROR_BIT = 15;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_FOREIGN,
        ACC_RD_FLAG,
        ACC_RD_WPORT,
        ACC_WR_FLAG,
        ACC_WR_RPORT
    } acc_kind_t;

    typedef enum logic {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_t;
endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
    import ctlreg_pkg::*;
(
    input  logic              valid,
    input  logic [SPRN_W-1:0] sprn,
    input  logic              write,
    output acc_kind_t         kind
);
    localparam logic [SPRN_W-1:0] RD_SEL = SPRN_W'(RD_NUM);
    localparam logic [SPRN_W-1:0] WR_SEL = SPRN_W'(WR_NUM);

    always_comb begin
        kind = ACC_FOREIGN;
        if (!valid) begin
            kind = ACC_IDLE;
        end else if (sprn == RD_SEL) begin
            kind = write ? ACC_WR_RPORT : ACC_RD_FLAG;
        end else if (sprn == WR_SEL) begin
            kind = write ? ACC_WR_FLAG : ACC_RD_WPORT;
        end
    end
endmodule

// File: rtl/ctlreg_runfsm.sv
module ctlreg_runfsm
    import ctlreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_bit,
    output logic run
);
    run_state_t state_q, state_d;

    // next-state process: T_START, T_STOP, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUNNING: if (load && !load_bit) state_d = ST_HALTED;   // T_STOP
            ST_HALTED:  if (load && load_bit)  state_d = ST_RUNNING;  // T_START
            default:    state_d = ST_RUNNING;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUNNING;
        else        state_q <= state_d;
    end

    always_comb run = (state_q == ST_RUNNING);
endmodule

// File: rtl/ctlreg_readfmt.sv
module ctlreg_readfmt
    import ctlreg_pkg::*;
(
    input  acc_kind_t         kind,
    input  logic              priv,
    input  logic              run,
    input  logic [DATA_W-1:0] old_val,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (kind)
            ACC_RD_FLAG: begin
                rdata[0]          = run;
                rdata[MIRROR_BIT] = run & priv;
            end
            ACC_RD_WPORT: rdata = old_val;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/ctlreg_access_unit.sv
module ctlreg_access_unit
    import ctlreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SPRN_W-1:0] req_sprn,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_old,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_handled,
    output logic              resp_illegal,
    output logic              resp_priv_fault,
    output logic              run_o
);
    acc_kind_t kind;
    logic      load;

    ctlreg_decode u_dec (
        .valid (req_valid),
        .sprn  (req_sprn),
        .write (req_write),
        .kind  (kind)
    );

    always_comb load = (kind == ACC_WR_FLAG) && req_priv;

    ctlreg_runfsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_bit (req_wdata[0]),
        .run      (run_o)
    );

    ctlreg_readfmt u_fmt (
        .kind    (kind),
        .priv    (req_priv),
        .run     (run_o),
        .old_val (req_old),
        .rdata   (resp_rdata)
    );

    // response flag process
    always_comb begin
        resp_handled    = 1'b0;
        resp_illegal    = 1'b0;
        resp_priv_fault = 1'b0;
        unique case (kind)
            ACC_IDLE, ACC_FOREIGN: ;
            ACC_RD_FLAG, ACC_WR_RPORT: resp_handled = 1'b1;
            ACC_RD_WPORT: begin
                resp_handled = 1'b1;
                resp_illegal = !req_priv;
            end
            ACC_WR_FLAG: begin
                resp_handled    = 1'b1;
                resp_priv_fault = !req_priv;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ctlreg_access_chk.sv
module ctlreg_access_chk
    import ctlreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [SPRN_W-1:0] req_sprn,
    input logic              req_write,
    input logic              req_priv,
    input logic [DATA_W-1:0] req_wdata,
    input logic [DATA_W-1:0] req_old,
    input logic [DATA_W-1:0] resp_rdata,
    input logic              resp_handled,
    input logic              resp_illegal,
    input logic              resp_priv_fault,
    input logic              run_o
);
    logic priv_wr, rd_flag, rd_wport_p, foreign;
    always_comb begin
        priv_wr    = req_valid && req_write && req_priv && req_sprn == SPRN_W'(WR_NUM);
        rd_flag    = req_valid && !req_write && req_sprn == SPRN_W'(RD_NUM);
        rd_wport_p = req_valid && !req_write && req_priv && req_sprn == SPRN_W'(WR_NUM);
        foreign    = req_valid && req_sprn != SPRN_W'(RD_NUM) && req_sprn != SPRN_W'(WR_NUM);
    end

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        priv_wr |=> run_o == $past(req_wdata[0]));

    assert_flag_guarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(priv_wr) |-> $stable(run_o));

    assert_read_image_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flag |-> resp_rdata == ({{(DATA_W-1){1'b0}}, run_o}
                                   | (DATA_W'(run_o && req_priv) << MIRROR_BIT)));

    assert_wport_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wport_p |-> (resp_rdata == req_old && resp_handled && !resp_illegal));

    assert_foreign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        foreign |-> (!resp_handled && !resp_illegal && !resp_priv_fault && resp_rdata == '0));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!resp_handled && !resp_illegal && !resp_priv_fault && resp_rdata == '0));

    assert_fault_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_illegal && resp_priv_fault) && ((resp_illegal || resp_priv_fault) -> resp_handled));
endmodule

bind ctlreg_access_unit ctlreg_access_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sprn(req_sprn),
    .req_write(req_write), .req_priv(req_priv), .req_wdata(req_wdata),
    .req_old(req_old), .resp_rdata(resp_rdata), .resp_handled(resp_handled),
    .resp_illegal(resp_illegal), .resp_priv_fault(resp_priv_fault), .run_o(run_o)
);

// File: tb/sim_ctlreg_access_unit.sv
module sim_ctlreg_access_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [9:0]  req_sprn = '0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_old = '0;
    logic [63:0] resp_rdata;
    logic        resp_handled, resp_illegal, resp_priv_fault, run_o;

    always #5 clk = ~clk;

    ctlreg_access_unit u0 (.*);

    typedef struct {
        logic [63:0] rdata;
        logic        handled, illegal, pfault, run;
        string       req;
    } exp_t;

    exp_t q[$];
    int   vectors = 0, errors = 0;
    logic run_m;
    bit   done = 0;

    task automatic send(input logic v, input int n, input logic w, input logic p,
                        input logic [63:0] wd, input logic [63:0] od, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_sprn = 10'(n); req_write = w; req_priv = p;
        req_wdata = wd; req_old = od;
        e.rdata = '0; e.handled = 0; e.illegal = 0; e.pfault = 0;
        e.run = run_m; e.req = tag;
        if (v) begin
            if (n == 136) begin
                e.handled = 1;
                if (!w) e.rdata = p ? ({48'd0, run_m, 14'd0, run_m}) : {63'd0, run_m};
            end else if (n == 152) begin
                e.handled = 1;
                if (w) begin
                    if (p) run_m = wd[0];
                    else   e.pfault = 1;
                end else begin
                    e.rdata = od;
                    e.illegal = !p;
                end
            end
        end
        q.push_back(e);
    endtask

    // monitor: compare each cycle's response against the queue head
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                vectors++;
                if (resp_rdata !== e.rdata || resp_handled !== e.handled ||
                    resp_illegal !== e.illegal || resp_priv_fault !== e.pfault ||
                    run_o !== e.run) begin
                    errors++;
                    $display("FAIL %s: got rd=%h h=%b ill=%b pf=%b run=%b exp rd=%h h=%b ill=%b pf=%b run=%b",
                             e.req, resp_rdata, resp_handled, resp_illegal, resp_priv_fault, run_o,
                             e.rdata, e.handled, e.illegal, e.pfault, e.run);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        run_m = 1'b1;
        @(negedge clk);
        vectors++;
        if (run_o !== 1'b1) begin errors++; $display("FAIL R1: run=%b exp 1", run_o); end
        send(1, 136, 0, 0, 0, 64'hAAAA, "R5 user read on");
        send(1, 136, 0, 1, 0, 64'hAAAA, "R6 priv read on");
        send(1, 152, 1, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, "R2 priv write 0");
        send(1, 136, 0, 0, 0, 64'h1234, "R5 user read off");
        send(1, 136, 0, 1, 0, 64'h1234, "R6 priv read off");
        send(1, 152, 1, 0, 64'h1, 0, "R3 user write");
        send(1, 136, 0, 1, 0, 0, "R3 flag held");
        send(1, 136, 1, 1, 64'h1, 0, "R4 write rport priv");
        send(1, 136, 1, 0, 64'h1, 0, "R4 write rport user");
        send(1, 136, 0, 0, 0, 0, "R4 flag held");
        send(1, 152, 1, 1, 64'h1, 0, "R2 priv write 1");
        send(1, 136, 0, 1, 0, 0, "R2 read back");
        send(1, 152, 0, 0, 0, 64'hDEAD_BEEF_0123_4567, "R7 user read wport");
        send(1, 152, 0, 1, 0, 64'hCAFE_F00D_8899_AABB, "R8 priv read wport");
        send(1, 137, 0, 1, 0, 64'h55, "R9 foreign 137");
        send(1, 153, 1, 1, 64'h0, 64'h55, "R9 foreign write 153");
        send(1, 1023, 0, 0, 0, 64'h55, "R9 foreign 1023");
        send(1, 8, 1, 1, 64'h0, 0, "R9 foreign 8 write");
        send(0, 152, 1, 1, 64'h0, 64'h77, "R10 idle write");
        send(0, 136, 0, 1, 0, 0, "R10 idle read");
        send(1, 136, 0, 1, 0, 0, "R10 flag held");
        send(0, 0, 0, 0, 0, 0, "R10 drain");
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule